// File: doc/BRIEF.md
# Prescaled Down-Counting Local Timer

This block is a per-core timer. Software loads a 32-bit start value. The count then steps down once per prescaler tick, and the tick rate is a power-of-two fraction of the clock. A control word chooses between two modes. In one-shot mode the count stops at zero. In periodic mode it reloads and runs again. The control word also holds an interrupt mask and an 8-bit vector.

When the count steps from one to zero, the block raises a one-clock expiry pulse. A qualified interrupt request carries the vector beside it, unless the mask is set. The vector is passed downstream; delivering it is not part of this block. The running count is always visible on an output. The stored divide setting can be read back.

The divide setting is a 4-bit field whose bit 2 is not used. Bits 3, 1 and 0 form a 3-bit code. That code, plus one and modulo eight, is the prescale shift.

Top module: `local_timer`

## Requirements
- R1: A write of the divide field keeps only bits 3, 1 and 0. Reading `div_cfg` returns {bit3, 0, bit1, bit0} of the last value written, and bit 2 has no effect on the tick rate.
- R2: With code c = {bit3, bit1, bit0}, one count step takes 2^((c+1) mod 8) clocks. So c=7 divides by 1, c=0 by 2, c=3 by 16 and c=6 by 128.
- R3: A start-value write sets `cur_count` to the written value one clock later and restarts the prescaler. The next step comes 2^shift clocks after the write edge, using the most recently written divide field.
- R4: In one-shot mode (control bit 17 = 0), after n ticks the count is max(start − n, 0), and it stays at zero.
- R5: In periodic mode (control bit 17 = 1), after n ticks the count is start − (n mod (start+1)), so it wraps from 0 back to the start value.
- R6: `expire` is high for exactly one clock, in the cycle where `cur_count` first reads 0 after reading 1.
- R7: `irq_valid` equals `expire` while control bit 16 (mask) is 0, and stays low while it is 1. `irq_vector` carries control bits 7:0.
- R8: A start value of 0 holds the count at 0 and never raises `expire`, including when it overrides a running count.
- R9: A divide write made mid-count does not change the count. The old rate holds until the next tick, and the new rate applies from that tick on.
- R10: After reset the count is 0, `expire` and `irq_valid` are low, `div_cfg` is 0 and the mask is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_wr | input | 1 | Start-value write strobe |
| init_val | input | CNT_W | Start value |
| div_wr | input | 1 | Divide field write strobe |
| div_val | input | 4 | Divide field |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_val | input | CTRL_W | Control word: [7:0] vector, [16] mask, [17] periodic |
| cur_count | output | CNT_W | Current count |
| div_cfg | output | 4 | Stored divide field |
| expire | output | 1 | One-clock expiry pulse |
| irq_valid | output | 1 | Unmasked expiry |
| irq_vector | output | VEC_W | Vector from the control word |

## Verification
Each error in the prescaler's active shift or phase has a visible cost. It moves every later count step by whole multiples of the tick period. The error shows on `cur_count` no later than the first tick after a start write, which is at most 128 clocks away.

A wrong reload copy or run flag has a different symptom. It shows at the first wrap or stop, as a count that does not return to the start value or does not hold at zero. A bad expiry flag shows in the same cycle the count reaches zero.

The bench therefore compares every output on every clock against the closed-form count. It does this across all eight divide codes, several start values and both modes.

// File: rtl/local_timer_pkg.sv
package local_timer_pkg;

    localparam int unsigned DIV_CFG_W = 4;
    localparam int unsigned SHIFT_W   = 3;
    // prescaler counter wide enough for the largest shift
    localparam int unsigned PRE_W     = (1 << SHIFT_W) - 1;

    typedef logic [SHIFT_W-1:0] shift_t;

    // only bits 3, 1, 0 are kept
    function automatic logic [DIV_CFG_W-1:0] div_cfg_keep(input logic [DIV_CFG_W-1:0] raw);
        return {raw[3], 1'b0, raw[1:0]};
    endfunction

    // code {b3,b1,b0}, shift = (code + 1) mod 8
    function automatic shift_t div_code_to_shift(input logic [DIV_CFG_W-1:0] cfg);
        shift_t code;
        code = {cfg[3], cfg[1:0]};
        return shift_t'(code + shift_t'(1));
    endfunction

endpackage

// File: rtl/lt_prescaler.sv
module lt_prescaler
    import local_timer_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 div_wr,
    input  logic [DIV_CFG_W-1:0] div_val,
    input  logic                 restart,
    output logic                 tick,
    output logic [DIV_CFG_W-1:0] div_cfg
);

    typedef struct packed {
        logic [DIV_CFG_W-1:0] cfg;
        shift_t               active;
        logic [PRE_W-1:0]     pre;
    } pre_state_t;

    localparam logic [PRE_W-1:0] PRE_ONES = '1;
    localparam pre_state_t       PRE_RST  = '{cfg: '0, active: shift_t'(1), pre: '0};

    pre_state_t       pre_q, pre_d;
    logic [PRE_W-1:0] limit;

    always_comb begin
        limit = ~(PRE_ONES << pre_q.active);
        tick  = (pre_q.pre == limit);
        pre_d = pre_q;
        if (div_wr) begin
            pre_d.cfg = div_cfg_keep(div_val);
        end
        // a new rate is adopted only at a boundary: restart or tick
        if (restart || tick) begin
            pre_d.pre    = '0;
            pre_d.active = div_code_to_shift(pre_d.cfg);
        end else begin
            pre_d.pre = pre_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= PRE_RST;
        end else begin
            pre_q <= pre_d;
        end
    end

    assign div_cfg = pre_q.cfg;

endmodule

// File: rtl/lt_downcount.sv
module lt_downcount #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             periodic,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] reload;
        logic             run;
        logic             exp;
    } cnt_state_t;

    cnt_state_t cnt_q, cnt_d;

    always_comb begin
        cnt_d     = cnt_q;
        cnt_d.exp = 1'b0;
        if (load) begin
            cnt_d.cnt    = load_val;
            cnt_d.reload = load_val;
            cnt_d.run    = (load_val != '0);
        end else if (tick && cnt_q.run) begin
            if (cnt_q.cnt == '0) begin
                if (periodic) begin
                    cnt_d.cnt = cnt_q.reload;
                end else begin
                    cnt_d.run = 1'b0;
                end
            end else begin
                cnt_d.cnt = cnt_q.cnt - CNT_ONE;
                if (cnt_q.cnt == CNT_ONE) begin
                    cnt_d.exp = 1'b1;
                    if (!periodic) begin
                        cnt_d.run = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count  = cnt_q.cnt;
    assign expire = cnt_q.exp;

endmodule

// File: rtl/local_timer.sv
module local_timer
    import local_timer_pkg::*;
#(
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned CTRL_W   = 32,
    parameter int unsigned VEC_W    = 8,
    parameter int unsigned MASK_POS = 16,
    parameter int unsigned MODE_POS = 17
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 init_wr,
    input  logic [CNT_W-1:0]     init_val,
    input  logic                 div_wr,
    input  logic [DIV_CFG_W-1:0] div_val,
    input  logic                 ctrl_wr,
    input  logic [CTRL_W-1:0]    ctrl_val,
    output logic [CNT_W-1:0]     cur_count,
    output logic [DIV_CFG_W-1:0] div_cfg,
    output logic                 expire,
    output logic                 irq_valid,
    output logic [VEC_W-1:0]     irq_vector
);

    localparam logic [CTRL_W-1:0] CTRL_RST = {{(CTRL_W-1){1'b0}}, 1'b1} << MASK_POS;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
    } top_state_t;

    top_state_t top_q, top_d;
    logic       tick;
    logic       mask_on;
    logic       mode_periodic;

    always_comb begin
        top_d = top_q;
        if (ctrl_wr) begin
            top_d.ctrl = ctrl_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '{ctrl: CTRL_RST};
        end else begin
            top_q <= top_d;
        end
    end

    assign mask_on       = top_q.ctrl[MASK_POS];
    assign mode_periodic = top_q.ctrl[MODE_POS];

    lt_prescaler u_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_wr  (div_wr),
        .div_val (div_val),
        .restart (init_wr),
        .tick    (tick),
        .div_cfg (div_cfg)
    );

    lt_downcount #(.CNT_W(CNT_W)) u_downcount (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (init_wr),
        .load_val (init_val),
        .tick     (tick),
        .periodic (mode_periodic),
        .count    (cur_count),
        .expire   (expire)
    );

    assign irq_valid  = expire & ~mask_on;
    assign irq_vector = top_q.ctrl[VEC_W-1:0];

endmodule

// File: rtl/local_timer_chk.sv
module local_timer_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init_wr,
    input logic [CNT_W-1:0] init_val,
    input logic             div_wr,
    input logic [3:0]       div_val,
    input logic [CNT_W-1:0] cur_count,
    input logic [3:0]       div_cfg,
    input logic             expire,
    input logic             irq_valid,
    input logic             mask_on,
    input logic             mode_periodic
);

    assert_div_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr |=> div_cfg == {$past(div_val[3]), 1'b0, $past(div_val[1:0])});

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !init_wr |=> (cur_count == $past(cur_count)
                      || cur_count == $past(cur_count) - 1'b1
                      || $past(cur_count) == '0));

    assert_oneshot_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_count == '0 && !init_wr && !mode_periodic) |=> cur_count == '0);

    assert_expire_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);

    assert_expire_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> cur_count == '0);

    assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (expire && !mask_on));

    assert_zero_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (init_wr && init_val == '0) |=> (cur_count == '0 && !expire));

endmodule

bind local_timer local_timer_chk #(.CNT_W(CNT_W)) u_local_timer_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .init_wr       (init_wr),
    .init_val      (init_val),
    .div_wr        (div_wr),
    .div_val       (div_val),
    .cur_count     (cur_count),
    .div_cfg       (div_cfg),
    .expire        (expire),
    .irq_valid     (irq_valid),
    .mask_on       (mask_on),
    .mode_periodic (mode_periodic)
);

// File: tb/test_local_timer.sv
`timescale 1ns/1ps
module test_local_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_wr = 1'b0;
    logic [31:0] init_val = '0;
    logic        div_wr = 1'b0;
    logic [3:0]  div_val = '0;
    logic        ctrl_wr = 1'b0;
    logic [31:0] ctrl_val = '0;
    logic [31:0] cur_count;
    logic [3:0]  div_cfg;
    logic        expire;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    int n_vec = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    local_timer i_local_timer (
        .clk(clk), .rst_n(rst_n),
        .init_wr(init_wr), .init_val(init_val),
        .div_wr(div_wr), .div_val(div_val),
        .ctrl_wr(ctrl_wr), .ctrl_val(ctrl_val),
        .cur_count(cur_count), .div_cfg(div_cfg),
        .expire(expire), .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_vec++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint ref_val(input longint init, input longint n, input bit per);
        if (per) return init - (n % (init + 1));
        return (n >= init) ? 0 : init - n;
    endfunction

    task automatic wr_div(input logic [3:0] v);
        @(negedge clk); div_wr = 1'b1; div_val = v;
        @(negedge clk); div_wr = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [31:0] v);
        @(negedge clk); ctrl_wr = 1'b1; ctrl_val = v;
        @(negedge clk); ctrl_wr = 1'b0;
    endtask

    // after return, state reflects the load edge (k = 0)
    task automatic wr_init(input logic [31:0] v);
        @(negedge clk); init_wr = 1'b1; init_val = v;
        @(negedge clk); init_wr = 1'b0;
    endtask

    task automatic run_case(input int code, input int init, input bit per);
        logic [3:0] raw;
        bit         msk;
        logic [7:0] vec;
        longint     p, kmax, n, e_cnt;
        bit         e_exp;
        raw = {code[2], code[0] ^ code[2], code[1:0]}; // bit 2 toggled freely (R1)
        msk = code[0] ^ per;
        vec = 8'(code * 29 + init * 3 + 1);
        p   = longint'(1) << ((code + 1) % 8);
        kmax = p * (2 * init + 3);
        wr_div(raw);
        wr_ctrl({14'd0, per, msk, 8'd0, vec});
        wr_init(32'(init));
        chk("R3", "count after load", cur_count, init);
        for (longint k = 1; k <= kmax; k++) begin
            @(negedge clk);
            n = k / p;
            e_cnt = ref_val(init, n, per);
            e_exp = (k % p == 0) && (e_cnt == 0) && (ref_val(init, n - 1, per) == 1);
            if (k == p) chk("R2", "first step", cur_count, init - 1);
            else if (k == p - 1) chk("R2", "before first step", cur_count, init);
            else if (per) chk("R5", "periodic count", cur_count, e_cnt);
            else chk("R4", "one-shot count", cur_count, e_cnt);
            chk("R6", "expire", expire, e_exp);
            chk("R7", "irq_valid", irq_valid, e_exp && !msk);
            if (e_exp && !msk) chk("R7", "irq_vector", irq_vector, vec);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_vec++;
        n_err++;
        $display("FAIL watchdog expired before completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin : main
        longint e;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "count", cur_count, 0);
        chk("R10", "expire", expire, 0);
        chk("R10", "irq_valid", irq_valid, 0);
        chk("R10", "div_cfg", div_cfg, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "count after release", cur_count, 0);
        wr_init(32'd1);   // default divide by 2, mask set after reset
        @(negedge clk);
        @(negedge clk);
        chk("R10", "expire with default divide", expire, 1);
        chk("R10", "irq masked by reset ctrl", irq_valid, 0);

        // R1: storage of the divide field
        for (int v = 0; v < 16; v++) begin
            wr_div(4'(v));
            chk("R1", "div_cfg readback", div_cfg, {v[3], 1'b0, v[1:0]});
        end

        // R2..R7 sweep over all codes, start values and modes
        for (int c = 0; c < 8; c++) begin
            foreach (int_list[i]) begin
                run_case(c, int_list[i], 1'b0);
                run_case(c, int_list[i], 1'b1);
            end
        end

        // R8: zero start value
        wr_div(4'b1011);
        wr_ctrl(32'h0000_0042);
        wr_init(32'd0);
        for (int k = 0; k < 150; k++) begin
            chk("R8", "count stays zero", cur_count, 0);
            chk("R8", "no expire", expire, 0);
            @(negedge clk);
        end
        wr_init(32'd20);
        repeat (5) @(negedge clk);
        wr_init(32'd0);
        for (int k = 0; k < 60; k++) begin
            chk("R8", "override stops", cur_count, 0);
            chk("R8", "no expire after override", expire, 0);
            @(negedge clk);
        end

        // R9: mid-count rate change (divide by 4 -> divide by 16)
        wr_div(4'b0001);
        wr_ctrl(32'h0001_0000);
        wr_init(32'd100);
        for (int k = 1; k <= 45; k++) begin
            @(negedge clk);
            e = (k < 8) ? 100 - k / 4 : 98 - (k - 8) / 16;
            chk("R9", "count across divide change", cur_count, e);
            if (k == 4) begin div_wr = 1'b1; div_val = 4'b0011; end
            if (k == 5) div_wr = 1'b0;
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    int int_list[4] = '{1, 2, 3, 5};

endmodule